// File: doc/BRIEF.md
# Transmit Descriptor Slot Engine

The block holds four transmit slots. Each slot has a buffer base address and a control/status word. Software loads a slot's base address, then writes its control word with a byte count and a start threshold. That write hands the slot to the engine. The engine reads the frame out of memory one 32-bit word at a time through a simple request/acknowledge port and stages the bytes in an internal byte FIFO. It then streams them, one byte per cycle, to a MAC byte interface. When the frame ends, the engine marks the slot as returned to software, records success or underrun, and raises a sticky interrupt flag.

Slots are served in a fixed rotation. A slot handed over out of turn waits until every slot before it in the rotation has been handed over and finished. The engine sends exactly the programmed number of bytes. It adds no padding and no checksum, so software must supply frames of at least 60 bytes. Collision reporting is not modelled, and those status bits read as zero.

Top module: `tx_slot_dma`

## Requirements
- R1: After reset every slot status reads 0x0000_2000, with bit 13 (software owns the slot) set and all other bits zero. Both interrupt flags, tx_valid and mem_rd are low.
- R2: The base address register of slot i sits at offset 0x20+4*i. Its bits 1:0 read back as zero, and the fetch uses the address with those bits cleared.
- R3: A write to offset 0x10+4*i while bit 13 of that slot is set does the following: it loads the byte count from bits 12:0 and the threshold from bits 21:16, clears bits 15:13 whatever value was written to them, and queues the slot.
- R4: The frame bytes leave in increasing address order. Within a memory word, byte k comes from bits 8k+7:8k. Exactly the programmed count of bytes is sent, with no padding. tx_last is high only with the final byte.
- R5: Slots are served in the order 0,1,2,3,0,... A slot queued out of turn sends nothing until the slots before it in the rotation have been queued and completed.
- R6: A control write to a slot whose bit 13 is clear is ignored.
- R7: The first byte of a frame goes out only after at least min(threshold*32, byte count) bytes have been fetched. Threshold 0 means one word. A frame larger than the FIFO also starts once the FIFO cannot take another word.
- R8: On a complete frame, bits 15 (sent OK) and 13 of the slot status become set, and irq_ok becomes set one cycle after tx_last.
- R9: If the FIFO runs empty before the last byte, the frame stops without tx_last, and the slot status shows bits 14 (underrun) and 13 set with bit 15 clear. irq_err is set, and the engine goes on with the next slot.
- R10: irq_ok and irq_err stay set until int_ack bit 0 or bit 1 respectively is pulsed. A new event in the same cycle wins over the clear.
- R11: Status bits 31:22 always read as zero, including collision and abort reporting.
- R12: mem_rd stays high with a stable, word-aligned mem_addr until mem_ack. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| mem_rd | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte valid toward the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| irq_ok | output | 1 | Sticky transmit-OK flag |
| irq_err | output | 1 | Sticky transmit-error flag |
| int_ack | input | 2 | Flag clear pulses: bit 0 OK, bit 1 error |

## Verification
Each fault inside the engine shows up at the ports in a specific way:
- A wrong FIFO pointer or byte-lane choice corrupts the very next byte on tx_data. The scoreboard catches it in the cycle the byte appears.
- A wrong fetch or sent count shows up as extra bytes, missing bytes, or a misplaced tx_last by the end of that frame.
- A wrong rotation pointer lets an out-of-turn slot transmit while the bench expects silence.
- A broken start threshold lets the first byte out before enough memory acknowledges have arrived. Under a throttled memory it also turns an expected clean frame into an underrun, which the status read after the frame exposes.

// File: rtl/tx_slot_dma.sv
module tx_slot_dma #(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        irq_ok,
  output logic        irq_err,
  input  logic [1:0]  int_ack
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SEND, S_DRAIN} state_t;

  state_t        state;
  logic [1:0]    cur;
  logic [12:0]   len_q  [4];
  logic [5:0]    thr_q  [4];
  logic [29:0]   base_q [4];
  logic [3:0]    own_q, und_q, ok_q;
  logic [12:0]   fetched, sent;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wptr, rptr;
  logic [7:0]    fifo [FIFO_DEPTH];

  wire       sel_ok  = reg_wr && reg_addr[1:0] == 2'b00;
  wire       wr_stat = sel_ok && reg_addr[7:4] == 4'h1;
  wire       wr_base = sel_ok && reg_addr[7:4] == 4'h2;
  wire [1:0] wslot   = reg_addr[3:2];

  wire [12:0] cur_len   = len_q[cur];
  wire [12:0] remain    = cur_len - fetched;
  wire [2:0]  nb        = (remain >= 13'd4) ? 3'd4 : remain[2:0];
  wire        active    = state == S_FILL || state == S_SEND;
  wire        push      = mem_rd && mem_ack && active;
  wire        pop       = tx_valid;
  wire [12:0] thr_bytes = {2'b00, thr_q[cur], 5'b0};
  wire        room      = cnt <= CW'(FIFO_DEPTH - 4);
  wire        start     = (cnt != '0 && 13'(cnt) >= thr_bytes) || fetched == cur_len || !room;
  wire        under     = state == S_SEND && cnt == '0;
  wire        fin_ok    = pop && sent == cur_len - 13'd1;
  wire        fin_err   = state == S_DRAIN && !mem_rd;
  wire        issue     = active && !mem_rd && fetched != cur_len && room && !under;

  assign tx_valid = state == S_SEND && cnt != '0;
  assign tx_data  = fifo[rptr];
  assign tx_last  = fin_ok;
  assign mem_addr = {base_q[cur], 2'b00} + {19'b0, fetched};

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr[7:4] == 4'h1)
        rd_data = {10'b0, thr_q[rd_addr[3:2]], ok_q[rd_addr[3:2]], und_q[rd_addr[3:2]],
                   own_q[rd_addr[3:2]], len_q[rd_addr[3:2]]};
      else if (rd_addr[7:4] == 4'h2)
        rd_data = {base_q[rd_addr[3:2]], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (push && i < int'(nb)) fifo[wptr + AW'(i)] <= mem_rdata[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur <= '0;
      own_q <= '1;
      und_q <= '0;
      ok_q <= '0;
      for (int i = 0; i < 4; i++) begin
        len_q[i] <= '0;
        thr_q[i] <= '0;
        base_q[i] <= '0;
      end
      fetched <= '0;
      sent <= '0;
      cnt <= '0;
      wptr <= '0;
      rptr <= '0;
      mem_rd <= 1'b0;
      irq_ok <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      if (wr_base) base_q[wslot] <= reg_wdata[31:2];
      if (wr_stat && own_q[wslot]) begin
        len_q[wslot] <= reg_wdata[12:0];
        thr_q[wslot] <= reg_wdata[21:16];
        own_q[wslot] <= 1'b0;
        und_q[wslot] <= 1'b0;
        ok_q[wslot]  <= 1'b0;
      end
      if (issue) mem_rd <= 1'b1;
      else if (mem_ack) mem_rd <= 1'b0;
      if (push) begin
        wptr <= wptr + AW'(nb);
        fetched <= fetched + 13'(nb);
      end
      if (pop) begin
        rptr <= rptr + 1'b1;
        sent <= sent + 13'd1;
      end
      cnt <= cnt + (push ? CW'(nb) : CW'(0)) - CW'(pop);
      irq_ok  <= (irq_ok  & ~int_ack[0]) | fin_ok;
      irq_err <= (irq_err & ~int_ack[1]) | fin_err;
      case (state)
        S_IDLE: if (!own_q[cur]) begin
          state <= S_FILL;
          fetched <= '0;
          sent <= '0;
        end
        S_FILL: if (start) state <= S_SEND;
        S_SEND: if (fin_ok) begin
          state <= S_IDLE;
          own_q[cur] <= 1'b1;
          ok_q[cur] <= 1'b1;
          cur <= cur + 2'd1;
        end else if (under) state <= S_DRAIN;
        S_DRAIN: if (!mem_rd) begin
          state <= S_IDLE;
          own_q[cur] <= 1'b1;
          und_q[cur] <= 1'b1;
          cnt <= '0;
          wptr <= '0;
          rptr <= '0;
          cur <= cur + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH));
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));
  assert_word_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'b00);
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  assert_last_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> irq_ok);
  assert_done_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ok_q | und_q) & ~own_q) == 4'b0);
  assert_ok_und_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q & und_q) == 4'b0);
endmodule

// File: tb/tb_tx_slot_dma.sv
module tb_tx_slot_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0, rd_addr = 0;
  logic [31:0] reg_wdata = 0, rd_data, mem_addr, mem_rdata = 0;
  logic mem_rd, mem_ack = 0, tx_valid, tx_last, irq_ok, irq_err;
  logic [7:0] tx_data;
  logic [1:0] int_ack = 0;

  tx_slot_dma dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, acked = 0, min_acked = 0;
  bit slow = 0, ignore_mode = 0, first_pending = 0, ign_last = 0;
  int ign_cnt = 0;
  logic [7:0] exp_q[$];
  bit last_q[$];

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int a;
    cyc++;
    mem_ack = mem_rd && (!slow || (cyc % 16 == 0));
    a = {mem_addr[31:2], 2'b00};
    mem_rdata = {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  end

  always @(posedge clk) if (mem_rd && mem_ack) acked += 4;

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (first_pending) begin
        first_pending = 0;
        chk(acked >= min_acked, "R7 start threshold", acked, min_acked);
      end
      if (ignore_mode) begin
        ign_cnt++;
        if (tx_last) ign_last = 1;
      end else if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected byte", {24'b0, tx_data}, 0);
      end else begin
        logic [7:0] e;
        bit l;
        e = exp_q.pop_front();
        l = last_q.pop_front();
        chk(tx_data == e, "R4 byte", {24'b0, tx_data}, {24'b0, e});
        chk(tx_last == l, "R4 last", {31'b0, tx_last}, {31'b0, l});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_frame(input int addr, input int len);
    for (int k = 0; k < len; k++) begin
      exp_q.push_back(pat((addr & ~3) + k));
      last_q.push_back(k == len - 1);
    end
  endtask

  task automatic wait_own(input int slot);
    logic [31:0] d;
    rd(8'(8'h10 + 4 * slot), d);
    while (!d[13]) begin
      @(negedge clk);
      rd(8'(8'h10 + 4 * slot), d);
    end
  endtask

  task automatic ack_pulse(input logic [1:0] v);
    @(negedge clk); int_ack = v;
    @(negedge clk); int_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h10 + 4 * s), d);
      chk(d == 32'h2000, "R1 reset status", d, 32'h2000);
    end
    chk({irq_ok, irq_err, tx_valid, mem_rd} == 4'b0, "R1 reset outputs",
        {28'b0, irq_ok, irq_err, tx_valid, mem_rd}, 0);

    // slot 0: unaligned base, junk in high and ownership bits
    wr(8'h20, 32'h103);
    rd(8'h20, d);
    chk(d == 32'h100, "R2 base readback", d, 32'h100);
    expect_frame(32'h100, 60);
    wr(8'h10, 32'hE000_E03C);
    rd(8'h10, d);
    chk(d == 32'h3C, "R3 R11 status after write", d, 32'h3C);
    wait_own(0);
    rd(8'h10, d);
    chk(d == 32'hA03C, "R8 R11 status done", d, 32'hA03C);
    chk(irq_ok && !irq_err, "R8 irq_ok", {30'b0, irq_ok, irq_err}, 2'b10);
    repeat (3) @(negedge clk);
    chk(irq_ok, "R10 sticky ok", {31'b0, irq_ok}, 1);
    ack_pulse(2'b01);
    chk(!irq_ok, "R10 ok cleared", {31'b0, irq_ok}, 0);
    chk(exp_q.size() == 0, "R4 frame complete", exp_q.size(), 0);

    // slot 2 queued out of turn, then slot 1
    wr(8'h28, 32'h200);
    wr(8'h24, 32'h180);
    wr(8'h18, 32'h0001_0015);
    repeat (20) @(negedge clk);
    rd(8'h18, d);
    chk(d == 32'h0001_0015, "R5 slot2 waits", d, 32'h0001_0015);
    wr(8'h18, 32'h32);
    rd(8'h18, d);
    chk(d == 32'h0001_0015, "R6 busy write ignored", d, 32'h0001_0015);
    expect_frame(32'h180, 20);
    expect_frame(32'h200, 21);
    wr(8'h14, 32'h14);
    wait_own(2);
    rd(8'h14, d);
    chk(d == 32'hA014, "R8 slot1 status", d, 32'hA014);
    rd(8'h18, d);
    chk(d == 32'h0001_A015, "R5 slot2 status", d, 32'h0001_A015);
    chk(exp_q.size() == 0, "R4 no padding", exp_q.size(), 0);
    ack_pulse(2'b01);

    // slot 3: threshold of one unit
    wr(8'h2C, 32'h40);
    expect_frame(32'h40, 60);
    acked = 0; min_acked = 32; first_pending = 1;
    wr(8'h1C, 32'h0001_003C);
    wait_own(3);
    rd(8'h1C, d);
    chk(d == 32'h0001_A03C, "R7 slot3 status", d, 32'h0001_A03C);
    ack_pulse(2'b01);

    // slot 0 again, throttled memory, no threshold: underrun
    slow = 1; ignore_mode = 1; ign_cnt = 0; ign_last = 0;
    wr(8'h20, 32'h0);
    wr(8'h10, 32'h3C);
    wait_own(0);
    rd(8'h10, d);
    chk(d == 32'h603C, "R9 underrun status", d, 32'h603C);
    chk(irq_err && !irq_ok, "R9 irq_err", {30'b0, irq_ok, irq_err}, 2'b01);
    chk(ign_cnt > 0 && ign_cnt < 60, "R9 partial bytes", ign_cnt, 4);
    chk(!ign_last, "R9 no tx_last", {31'b0, ign_last}, 0);
    ack_pulse(2'b10);
    chk(!irq_err, "R10 err cleared", {31'b0, irq_err}, 0);
    ignore_mode = 0;

    // slot 1, throttled memory, threshold covering frame
    wr(8'h24, 32'h300);
    expect_frame(32'h300, 60);
    acked = 0; min_acked = 60; first_pending = 1;
    wr(8'h14, 32'h0002_003C);
    wait_own(1);
    rd(8'h14, d);
    chk(d == 32'h0002_A03C, "R9 R7 recovery status", d, 32'h0002_A03C);
    chk(exp_q.size() == 0, "R4 frame complete", exp_q.size(), 0);
    slow = 0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule